// File: doc/BRIEF.md
# Utilization-Driven Clock and Voltage Controller

This block sits in each tile next to a processing core and picks the core's clock rate and supply rail from how often the core's stream ports stall. It watches two stall indications from the core-ports. An input port that cannot deliver because the core has not taken the previous word says the core runs too slowly. An output port that cannot hand off because the network has not drained it says the core runs faster than needed. Over a fixed window of interconnect cycles it counts both kinds of stall. At the end of each window it moves one step up or down a ladder of four speed levels, or stays where it is.

Each level pairs a clock divided down from the distributed interconnect clock (full rate, half, quarter or eighth) with one pre-routed supply rail. The block produces a one-cycle enable pulse that a clock-gating stage downstream turns into the core clock. It also drives a one-hot rail select. Speeding up raises the rail first and switches the divider only after a programmable settle time. Slowing down switches the divider first and lowers the rail afterwards. Divider changes only take effect on a period boundary. The tile's own controller can pin the level through a force input, and while the force is held the stall statistics are ignored.

Top module: `dvfs_util_ctrl`

## Requirements
- R1: Stall events are counted over windows of WIN_CYCLES (default 256) reference cycles. The first window starts on the first clock edge after reset is released, and each later window starts on the edge after the previous one ends. The decision for a window uses only the events sampled during it.
- R2: At the end of a window, if the input-stall count is strictly greater than `in_thresh` and the output-stall count is not greater than `out_thresh`, the level moves one step faster (level number minus one).
- R3: At the end of a window, if the output-stall count is strictly greater than `out_thresh` and the input-stall count is not greater than `in_thresh`, the level moves one step slower (level number plus one).
- R4: If both counts exceed their thresholds, or neither does, the level is held. A count equal to its threshold does not exceed it.
- R5: The level saturates. A faster step at level 0 and a slower step at level 3 leave the level unchanged.
- R6: `cur_lvl` encodes the divider in effect: 0 means divide by 1, 1 by 2, 2 by 4 and 3 by 8. `clk_en` is a single-cycle pulse every 2^`cur_lvl` cycles. A new level takes effect only on a pulse, so each interval between pulses equals the full period of the level that was in effect at the start of that interval.
- R7: `rail_sel` is one-hot, with bit i selecting the rail paired with level i. Bit 0 is the highest supply (1.8 V), then 1.16 V, 0.73 V, and bit 3 is the lowest (0.6 V). The selected rail is never lower than the one paired with the divider in effect.
- R8: On a move to a faster level, `rail_sel` changes first, and `cur_lvl` changes at least `settle_cycles`+1 cycles after `rail_sel`.
- R9: On a move to a slower level, `cur_lvl` changes first, and `rail_sel` changes afterwards.
- R10: While `force_en` is high, the target level follows `force_lvl` and window decisions are ignored. After release, automatic stepping resumes from the level reached.
- R11: Synchronous active-high reset gives level 0 (full speed), `rail_sel` = 4'b0001 and `clk_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect reference clock |
| rst | input | 1 | Synchronous active-high reset |
| in_blocked | input | 1 | Input core-port stalled this cycle |
| out_blocked | input | 1 | Output core-port stalled this cycle |
| in_thresh | input | CNT_W (9) | Input-stall count that must be exceeded to speed up |
| out_thresh | input | CNT_W (9) | Output-stall count that must be exceeded to slow down |
| settle_cycles | input | SETTLE_W (8) | Wait between a rail rise and the divider switch |
| force_en | input | 1 | Pin the level to `force_lvl` |
| force_lvl | input | LVL_W (2) | Level used while forced |
| clk_en | output | 1 | Divider enable pulse |
| rail_sel | output | NUM_LVL (4) | One-hot supply rail select |
| cur_lvl | output | LVL_W (2) | Divider level in effect |

## Verification
A table of window patterns drives both stall inputs with chosen counts from a known level. It separates an input-only excess, an output-only excess, both, neither, and counts that exactly equal a threshold. It also covers steps that would go past either end of the ladder and maximum-count windows. Forced jumps in both directions are watched cycle by cycle to tell the raise-first ordering from the divide-first ordering, and to show that the settle wait is honoured. A forced window with heavy input stalls checks that statistics are ignored and that stepping resumes after release. The spacing of every enable pulse is compared against the level in effect, which catches any interval cut short at a level change.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETTLE,
    SQ_UPWAIT,
    SQ_DNWAIT
  } seq_state_t;
endpackage

// File: rtl/dvfs_stall_window.sv
module dvfs_stall_window #(
  parameter int WIN_CYCLES = 256,
  parameter int CNT_W      = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_blocked,
  input  logic             out_blocked,
  output logic             win_v,
  output logic [CNT_W-1:0] in_tot,
  output logic [CNT_W-1:0] out_tot
);
  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

  logic [WIN_W-1:0] wcnt;
  logic [CNT_W-1:0] in_acc, out_acc;
  logic             last;

  assign last = (wcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt    <= '0;
      in_acc  <= '0;
      out_acc <= '0;
      in_tot  <= '0;
      out_tot <= '0;
      win_v   <= 1'b0;
    end else begin
      win_v <= last;
      if (last) begin
        wcnt    <= '0;
        in_tot  <= in_acc + CNT_W'(in_blocked);
        out_tot <= out_acc + CNT_W'(out_blocked);
        in_acc  <= '0;
        out_acc <= '0;
      end else begin
        wcnt    <= wcnt + 1'b1;
        in_acc  <= in_acc + CNT_W'(in_blocked);
        out_acc <= out_acc + CNT_W'(out_blocked);
      end
    end
  end

  // R1: a window-end strobe lasts one cycle
  a_r1_win_single: assert property (@(posedge clk) disable iff (rst)
    win_v |=> !win_v);

  // R1: a window never holds more events than it has cycles
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    win_v |-> (in_tot <= CNT_W'(WIN_CYCLES)) && (out_tot <= CNT_W'(WIN_CYCLES)));
endmodule

// File: rtl/dvfs_div_en.sv
module dvfs_div_en #(
  parameter int NUM_LVL = 4,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] req_lvl,
  output logic             en,
  output logic [LVL_W-1:0] eff_lvl
);
  localparam int DCW = (NUM_LVL > 1) ? NUM_LVL - 1 : 1;

  logic [DCW-1:0] cnt;
  logic [DCW-1:0] period_m1;

  assign period_m1 = DCW'((1 << eff_lvl) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      en      <= 1'b0;
      eff_lvl <= '0;
    end else if (cnt == period_m1) begin
      cnt     <= '0;
      en      <= 1'b1;
      eff_lvl <= req_lvl;
    end else begin
      cnt <= cnt + 1'b1;
      en  <= 1'b0;
    end
  end

  // R6: the divider level only moves together with an enable pulse
  a_r6_switch_on_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(eff_lvl) |-> en);

  // R6: below full rate, pulses are never back to back
  a_r6_no_short_pulse: assert property (@(posedge clk) disable iff (rst)
    (en && eff_lvl != '0) |=> !en);
endmodule

// File: rtl/dvfs_lvl_seq.sv
module dvfs_lvl_seq
  import dvfs_pkg::*;
#(
  parameter int NUM_LVL  = 4,
  parameter int LVL_W    = $clog2(NUM_LVL),
  parameter int CNT_W    = 9,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                win_v,
  input  logic [CNT_W-1:0]    in_tot,
  input  logic [CNT_W-1:0]    out_tot,
  input  logic [CNT_W-1:0]    in_thresh,
  input  logic [CNT_W-1:0]    out_thresh,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                force_en,
  input  logic [LVL_W-1:0]    force_lvl,
  input  logic [LVL_W-1:0]    eff_lvl,
  output logic [LVL_W-1:0]    div_req,
  output logic [NUM_LVL-1:0]  rail_sel
);
  localparam logic [LVL_W-1:0] SLOWEST = LVL_W'(NUM_LVL - 1);

  seq_state_t          st;
  logic [LVL_W-1:0]    goal, mv;
  logic [SETTLE_W-1:0] scnt;
  logic                want_up, want_dn;

  assign want_up = (in_tot > in_thresh) && !(out_tot > out_thresh);
  assign want_dn = (out_tot > out_thresh) && !(in_tot > in_thresh);

  // target level: forced, or stepped once per window
  always_ff @(posedge clk) begin
    if (rst) begin
      goal <= '0;
    end else if (force_en) begin
      goal <= force_lvl;
    end else if (win_v) begin
      if (want_up && goal != '0)
        goal <= goal - 1'b1;
      else if (want_dn && goal != SLOWEST)
        goal <= goal + 1'b1;
    end
  end

  // ordering of rail and divider changes
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      div_req  <= '0;
      mv       <= '0;
      scnt     <= '0;
      rail_sel <= NUM_LVL'(1);
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (goal < div_req) begin
            mv       <= goal;
            rail_sel <= NUM_LVL'(1) << goal;
            scnt     <= settle_cycles;
            st       <= SQ_SETTLE;
          end else if (goal > div_req) begin
            div_req <= goal;
            st      <= SQ_DNWAIT;
          end
        end
        SQ_SETTLE: begin
          if (scnt == '0) begin
            div_req <= mv;
            st      <= SQ_UPWAIT;
          end else begin
            scnt <= scnt - 1'b1;
          end
        end
        SQ_UPWAIT: begin
          if (eff_lvl == div_req) st <= SQ_IDLE;
        end
        SQ_DNWAIT: begin
          if (eff_lvl == div_req) begin
            rail_sel <= NUM_LVL'(1) << div_req;
            st       <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R10: a forced level is taken as the target on the next cycle
  a_r10_force_tracks: assert property (@(posedge clk) disable iff (rst)
    force_en |=> goal == $past(force_lvl));

  // R2/R3: unforced, the target moves by at most one step
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    !force_en |=> (goal == $past(goal)) || (goal == $past(goal) + 1'b1) ||
                  (goal == $past(goal) - 1'b1));

  // R8: a faster divider request finds its rail already raised
  a_r8_rail_leads: assert property (@(posedge clk) disable iff (rst)
    (div_req < $past(div_req)) |-> rail_sel == (NUM_LVL'(1) << div_req));

  // R9: the rail is lowered only once the divider has already slowed
  a_r9_rail_trails: assert property (@(posedge clk) disable iff (rst)
    (rail_sel > $past(rail_sel)) |-> rail_sel == (NUM_LVL'(1) << eff_lvl));
endmodule

// File: rtl/dvfs_util_ctrl.sv
module dvfs_util_ctrl #(
  parameter int WIN_CYCLES = 256,
  parameter int NUM_LVL    = 4,
  parameter int SETTLE_W   = 8,
  localparam int LVL_W     = $clog2(NUM_LVL),
  localparam int CNT_W     = $clog2(WIN_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_blocked,
  input  logic                out_blocked,
  input  logic [CNT_W-1:0]    in_thresh,
  input  logic [CNT_W-1:0]    out_thresh,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                force_en,
  input  logic [LVL_W-1:0]    force_lvl,
  output logic                clk_en,
  output logic [NUM_LVL-1:0]  rail_sel,
  output logic [LVL_W-1:0]    cur_lvl
);
  logic             win_v;
  logic [CNT_W-1:0] in_tot, out_tot;
  logic [LVL_W-1:0] div_req;

  dvfs_stall_window #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst),
    .in_blocked(in_blocked), .out_blocked(out_blocked),
    .win_v(win_v), .in_tot(in_tot), .out_tot(out_tot)
  );

  dvfs_lvl_seq #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .CNT_W(CNT_W),
                 .SETTLE_W(SETTLE_W)) u_seq (
    .clk(clk), .rst(rst),
    .win_v(win_v), .in_tot(in_tot), .out_tot(out_tot),
    .in_thresh(in_thresh), .out_thresh(out_thresh),
    .settle_cycles(settle_cycles),
    .force_en(force_en), .force_lvl(force_lvl),
    .eff_lvl(cur_lvl), .div_req(div_req), .rail_sel(rail_sel)
  );

  dvfs_div_en #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_div (
    .clk(clk), .rst(rst),
    .req_lvl(div_req), .en(clk_en), .eff_lvl(cur_lvl)
  );

  // R7: exactly one rail selected
  a_r7_rail_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(rail_sel) == 1);

  // R7: the rail never sits below the one the running divider needs
  a_r7_rail_not_low: assert property (@(posedge clk) disable iff (rst)
    (rail_sel >> cur_lvl) <= 1);
endmodule

// File: tb/sim_dvfs_util_ctrl.sv
`timescale 1ns/1ps
module sim_dvfs_util_ctrl;
  localparam int WIN = 256;
  localparam int NL  = 4;
  localparam int LW  = 2;
  localparam int CW  = 9;
  localparam int SW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_b = 1'b0, out_b = 1'b0;
  logic [CW-1:0] in_thr = 9'd5, out_thr = 9'd5;
  logic [SW-1:0] settle = 8'd4;
  logic          frc = 1'b0;
  logic [LW-1:0] frc_lvl = '0;
  logic          clk_en;
  logic [NL-1:0] rail_sel;
  logic [LW-1:0] cur_lvl;

  always #2.5 clk = ~clk;

  dvfs_util_ctrl #(.WIN_CYCLES(WIN), .NUM_LVL(NL), .SETTLE_W(SW)) u0 (
    .clk(clk), .rst(rst), .in_blocked(in_b), .out_blocked(out_b),
    .in_thresh(in_thr), .out_thresh(out_thr), .settle_cycles(settle),
    .force_en(frc), .force_lvl(frc_lvl),
    .clk_en(clk_en), .rail_sel(rail_sel), .cur_lvl(cur_lvl)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  // pulse spacing monitor for R6
  int gap = 0, gap_err = 0, pulses = 0, prev_lvl = 0;
  bit have_prev = 0;
  always @(negedge clk) begin
    if (rst) begin
      have_prev = 0;
      gap = 0;
    end else begin
      gap++;
      if (clk_en) begin
        if (have_prev && gap != (1 << prev_lvl)) begin
          gap_err++;
          $display("FAIL R6 pulse gap: got %0d expected %0d", gap, 1 << prev_lvl);
        end
        have_prev = 1;
        prev_lvl  = cur_lvl;
        gap       = 0;
        pulses++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic align;
    while (cyc % WIN != 0) @(negedge clk);
  endtask

  task automatic run_window(input int in_n, input int out_n);
    align();
    for (int i = 0; i < WIN; i++) begin
      in_b  = (i < in_n);
      out_b = (i < out_n);
      @(negedge clk);
    end
    in_b  = 1'b0;
    out_b = 1'b0;
  endtask

  task automatic check_level(input int lvl, input string tag);
    chk(cur_lvl == lvl, tag, cur_lvl, lvl);
    chk(rail_sel == (4'b0001 << lvl), "R7 rail pairing", rail_sel, 1 << lvl);
  endtask

  // forced jump with the order of rail and divider changes recorded
  task automatic move_watch(input int target, input bit faster);
    int rk = -1, lk = -1;
    logic [NL-1:0] r0 = rail_sel;
    logic [LW-1:0] l0 = cur_lvl;
    frc     = 1'b1;
    frc_lvl = LW'(target);
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (rk < 0 && rail_sel != r0) rk = k;
      if (lk < 0 && cur_lvl != l0) lk = k;
      if (rk >= 0 && lk >= 0 && cur_lvl == target && rail_sel == (4'b0001 << target))
        break;
    end
    if (faster) begin
      chk(rk >= 0 && rk < lk, "R8 rail rises before divider", rk, lk);
      chk(lk - rk >= int'(settle) + 1, "R8 settle wait", lk - rk, int'(settle) + 1);
    end else begin
      chk(lk >= 0 && lk < rk, "R9 divider slows before rail", lk, rk);
    end
    check_level(target, faster ? "R8 final level" : "R9 final level");
  endtask

  // in-stall count, out-stall count, expected level, requirement
  localparam int VEC [10][4] = '{
    '{0,   20,  1, 3},
    '{0,   6,   2, 3},
    '{0,   200, 3, 3},
    '{0,   256, 3, 5},
    '{10,  10,  3, 4},
    '{5,   0,   3, 4},
    '{6,   0,   2, 2},
    '{256, 0,   1, 2},
    '{50,  5,   0, 4},
    '{50,  0,   0, 5}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(clk_en == 1'b0, "R11 enable low in reset", clk_en, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cur_lvl == 0, "R11 reset level", cur_lvl, 0);
    chk(rail_sel == 4'b0001, "R11 reset rail", rail_sel, 1);
    @(negedge clk);
    chk(clk_en == 1'b1, "R6 full-rate pulse", clk_en, 1);

    // R1 R2 R3 R4 R5: one window per vector, then a quiet window
    for (int v = 0; v < 10; v++) begin
      string tg;
      case (VEC[v][3])
        2:       tg = "R2 step faster";
        3:       tg = "R3 step slower";
        4:       tg = "R4 hold";
        default: tg = "R5 saturate";
      endcase
      run_window(VEC[v][0], VEC[v][1]);
      repeat (128) @(negedge clk);
      check_level(VEC[v][2], tg);
    end

    // R1: events straddling two windows split between them (3+3 stays at 0)
    align();
    repeat (WIN - 3) @(negedge clk);
    out_b = 1'b1;
    repeat (6) @(negedge clk);
    out_b = 1'b0;
    repeat (WIN + 64) @(negedge clk);
    check_level(0, "R1 window split");

    // R8 R9: ordering around forced jumps with a long settle
    settle = 8'd20;
    move_watch(3, 1'b0);
    move_watch(1, 1'b1);

    // R10: while forced, heavy input stalls are ignored
    run_window(200, 0);
    repeat (10) @(negedge clk);
    frc = 1'b0;
    repeat (118) @(negedge clk);
    check_level(1, "R10 forced ignores stats");
    run_window(200, 0);
    repeat (128) @(negedge clk);
    check_level(0, "R10 auto resumes");

    chk(gap_err == 0 && pulses > 100, "R6 pulse spacing", gap_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule